// File: doc/BRIEF.md
# Modem Line Flow Gate

This block sits between two active-low modem-status pins and the shifters of a serial controller. Each pin goes through a synchroniser and a debounce filter. The cleaned levels can then drive one of two things. In gated mode, the clear-to-send line decides whether the transmitter may run, and the carrier-detect line decides whether the receiver may run. In open mode, both enables stay on, and software only reads the two lines as plain status bits.

A change on either cleaned line, in either direction, sets a sticky change flag for that line. Software clears a flag by writing a one to it. Each flag has its own enable, and the interrupt output is high whenever an enabled flag is set.

When clear-to-send goes away in gated mode, the transmitter enable stays high while the transmitter reports a character in progress. It drops only after that character is done. The register port is 4 bits wide and uses a one-bit address. Register 0 is control: bit 0 selects gated mode, bit 1 enables the clear-to-send interrupt, bit 2 enables the carrier-detect interrupt. Register 1 is status.

Top module: `line_gate_ctrl`

## Requirements
- R1: After reset, tx_enable_o and rx_enable_o are 1, irq_o is 0, control reads 0, and status reads 0 while both pins are high.
- R2: With control bit 0 clear, tx_enable_o and rx_enable_o stay 1 whatever the pins do. Status bit 0 reads 1 while the cleaned clear-to-send pin is low, and status bit 1 reads 1 while the cleaned carrier-detect pin is low.
- R3: With control bit 0 set and no character in progress, tx_enable_o is 1 exactly when the cleaned clear-to-send pin is low.
- R4: If tx_enable_o is 1 and tx_busy_i is 1, tx_enable_o stays 1 on the next cycle. Once tx_busy_i falls while clear-to-send is inactive in gated mode, tx_enable_o goes to 0 one clock edge later.
- R5: With control bit 0 set, rx_enable_o is 1 exactly when the cleaned carrier-detect pin is low. It is independent of clear-to-send.
- R6: A pin level that has been held for DEB_LEN cycles shows in status exactly DEB_LEN+2 clock edges after it was applied. It shows on the enables and change flags one edge after that. A pulse of DEB_LEN-1 cycles or shorter has no effect.
- R7: A cleaned change of clear-to-send, high-to-low or low-to-high, sets status bit 2. A cleaned change of carrier-detect, in either direction, sets status bit 3.
- R8: Writing 1 to status bit 2 or bit 3 clears that flag. A flag written with 0 keeps its value.
- R9: irq_o is 1 exactly when (status bit 2 and control bit 1) or (status bit 3 and control bit 2). It updates on the same edge as the flags.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cts_n_i | input | 1 | Raw clear-to-send pin, active low, asynchronous |
| dcd_n_i | input | 1 | Raw carrier-detect pin, active low, asynchronous |
| tx_busy_i | input | 1 | Transmitter has a character in progress |
| wr_en_i | input | 1 | Register write strobe |
| wr_addr_i | input | 1 | Write address: 0 control, 1 status |
| wr_data_i | input | 4 | Write data |
| rd_addr_i | input | 1 | Read address: 0 control, 1 status |
| rd_data_o | output | 4 | Read data, combinational from rd_addr_i |
| tx_enable_o | output | 1 | Transmitter permitted to run |
| rx_enable_o | output | 1 | Receiver permitted to run |
| irq_o | output | 1 | Interrupt request, active high |

## Verification
The pins are driven with long steps and with short glitches. Long steps must appear after the exact pipeline delay, and glitches must leave no trace. This separates correct filtering from both a missing filter and a filter of the wrong length.

Both pins are swept in open mode and in gated mode. Open mode must pass the pins through to status only. Gated mode must move only the matching enable, which exposes any swapped or cross-coupled gating.

Clear-to-send is dropped during a busy character to expose an early cut-off. Both edge directions are applied with the interrupt enables set differently, and flags are cleared one at a time. This shows whether flags, enables and clears act per pin.

// File: rtl/lgc_pkg.sv
package lgc_pkg;
    localparam int NLINES   = 2;
    localparam int LINE_CTS = 0;
    localparam int LINE_DCD = 1;
    localparam int REG_W    = 4;

    localparam logic ADDR_CTRL = 1'b0;
    localparam logic ADDR_STAT = 1'b1;

    typedef struct packed {
        logic              auto_en;
        logic [NLINES-1:0] ie;
        logic [NLINES-1:0] flag;
        logic              tx_en;
        logic              rx_en;
        logic              irq;
    } gate_state_t;

    typedef struct packed {
        logic [7:0] cnt;
        logic       filt;
        logic       tog;
    } deb_state_t;
endpackage

// File: rtl/lgc_sync.sv
module lgc_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic din,
    output logic dout
);
    logic [STAGES-1:0] chain_d, chain_q;

    generate
        if (STAGES == 1) begin : g_one
            always_comb chain_d = din;
        end else begin : g_many
            always_comb chain_d = {chain_q[STAGES-2:0], din};
        end
    endgenerate

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain_q <= '1;
        else        chain_q <= chain_d;
    end

    assign dout = chain_q[STAGES-1];
endmodule

// File: rtl/lgc_debounce.sv
module lgc_debounce import lgc_pkg::*; #(
    parameter int DEB_LEN = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic sample,
    output logic level,
    output logic toggled
);
    localparam logic [7:0] LAST = 8'(DEB_LEN - 1);

    deb_state_t s_d, s_q;

    always_comb begin
        s_d     = s_q;
        s_d.tog = 1'b0;
        if (sample != s_q.filt) begin
            if (s_q.cnt == LAST) begin
                s_d.filt = sample;
                s_d.cnt  = '0;
                s_d.tog  = 1'b1;
            end else begin
                s_d.cnt = s_q.cnt + 8'd1;
            end
        end else begin
            s_d.cnt = '0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q.cnt  <= '0;
            s_q.filt <= 1'b1;
            s_q.tog  <= 1'b0;
        end else begin
            s_q <= s_d;
        end
    end

    assign level   = s_q.filt;
    assign toggled = s_q.tog;
endmodule

// File: rtl/line_gate_ctrl.sv
module line_gate_ctrl import lgc_pkg::*; #(
    parameter int SYNC_STAGES = 2,
    parameter int DEB_LEN     = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cts_n_i,
    input  logic             dcd_n_i,
    input  logic             tx_busy_i,
    input  logic             wr_en_i,
    input  logic             wr_addr_i,
    input  logic [REG_W-1:0] wr_data_i,
    input  logic             rd_addr_i,
    output logic [REG_W-1:0] rd_data_o,
    output logic             tx_enable_o,
    output logic             rx_enable_o,
    output logic             irq_o
);
    logic [NLINES-1:0] raw_n, sync_n, filt_n, tog, act;
    gate_state_t s_d, s_q;

    logic              auto_q;
    logic [NLINES-1:0] ie_q;
    logic [NLINES-1:0] flag_q;

    assign raw_n[LINE_CTS] = cts_n_i;
    assign raw_n[LINE_DCD] = dcd_n_i;

    generate
        for (genvar i = 0; i < NLINES; i++) begin : g_line
            lgc_sync #(.STAGES(SYNC_STAGES)) u_sync (
                .clk  (clk),
                .rst_n(rst_n),
                .din  (raw_n[i]),
                .dout (sync_n[i])
            );
            lgc_debounce #(.DEB_LEN(DEB_LEN)) u_deb (
                .clk    (clk),
                .rst_n  (rst_n),
                .sample (sync_n[i]),
                .level  (filt_n[i]),
                .toggled(tog[i])
            );
        end
    endgenerate

    assign act = ~filt_n;

    always_comb begin
        logic [NLINES-1:0] clr;
        s_d = s_q;
        clr = '0;
        if (wr_en_i && wr_addr_i == ADDR_CTRL) begin
            s_d.auto_en = wr_data_i[0];
            s_d.ie      = wr_data_i[2:1];
        end
        if (wr_en_i && wr_addr_i == ADDR_STAT) clr = wr_data_i[3:2];
        s_d.flag  = (s_q.flag & ~clr) | tog;
        s_d.tx_en = !s_q.auto_en || act[LINE_CTS] || (s_q.tx_en && tx_busy_i);
        s_d.rx_en = !s_q.auto_en || act[LINE_DCD];
        s_d.irq   = |(s_d.flag & s_d.ie);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q.auto_en <= 1'b0;
            s_q.ie      <= '0;
            s_q.flag    <= '0;
            s_q.tx_en   <= 1'b1;
            s_q.rx_en   <= 1'b1;
            s_q.irq     <= 1'b0;
        end else begin
            s_q <= s_d;
        end
    end

    assign auto_q = s_q.auto_en;
    assign ie_q   = s_q.ie;
    assign flag_q = s_q.flag;

    always_comb begin
        if (rd_addr_i == ADDR_CTRL) rd_data_o = {1'b0, ie_q, auto_q};
        else                        rd_data_o = {flag_q, act};
    end

    assign tx_enable_o = s_q.tx_en;
    assign rx_enable_o = s_q.rx_en;
    assign irq_o       = s_q.irq;
endmodule

// File: rtl/lgc_checker.sv
module lgc_checker (
    input logic       clk,
    input logic       rst_n,
    input logic       tx_busy_i,
    input logic       wr_en_i,
    input logic       wr_addr_i,
    input logic [3:0] wr_data_i,
    input logic       tx_enable_o,
    input logic       rx_enable_o,
    input logic       irq_o,
    input logic       auto_q,
    input logic [1:0] ie_q,
    input logic [1:0] flag_q,
    input logic [1:0] act,
    input logic [1:0] tog
);
    // R2
    a_r2_open_mode: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(auto_q) |-> (tx_enable_o && rx_enable_o));

    // R3
    a_r3_tx_closed: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(auto_q) && !$past(act[0]) && !$past(tx_busy_i)) |-> !tx_enable_o);

    // R4
    a_r4_hold_busy: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_enable_o && tx_busy_i) |=> tx_enable_o);

    // R5
    a_r5_rx_closed: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(auto_q) && !$past(act[1])) |-> !rx_enable_o);

    // R7
    a_r7_cts_flag_src: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(flag_q[0]) |-> $past(tog[0]));
    a_r7_dcd_flag_src: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(flag_q[1]) |-> $past(tog[1]));

    // R8
    a_r8_cts_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (flag_q[0] && !(wr_en_i && wr_addr_i && wr_data_i[2])) |=> flag_q[0]);
    a_r8_dcd_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (flag_q[1] && !(wr_en_i && wr_addr_i && wr_data_i[3])) |=> flag_q[1]);

    // R9
    a_r9_irq_source: assert property (@(posedge clk) disable iff (!rst_n)
        irq_o |-> |(flag_q & ie_q));
endmodule

bind line_gate_ctrl lgc_checker u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .tx_busy_i  (tx_busy_i),
    .wr_en_i    (wr_en_i),
    .wr_addr_i  (wr_addr_i),
    .wr_data_i  (wr_data_i),
    .tx_enable_o(tx_enable_o),
    .rx_enable_o(rx_enable_o),
    .irq_o      (irq_o),
    .auto_q     (auto_q),
    .ie_q       (ie_q),
    .flag_q     (flag_q),
    .act        (act),
    .tog        (tog)
);

// File: tb/line_gate_ctrl_tb.sv
module line_gate_ctrl_tb;
    localparam int CLK_PERIOD = 10;
    localparam int DEB        = 4;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       cts_n = 1'b1, dcd_n = 1'b1, busy = 1'b0;
    logic       wr_en = 1'b0, wr_addr = 1'b0, rd_addr = 1'b0;
    logic [3:0] wr_data = '0, rd_data;
    logic       tx_en, rx_en, irq;

    int n_chk = 0;
    int n_bad = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    line_gate_ctrl #(.SYNC_STAGES(2), .DEB_LEN(DEB)) u_dut (
        .clk(clk), .rst_n(rst_n), .cts_n_i(cts_n), .dcd_n_i(dcd_n),
        .tx_busy_i(busy), .wr_en_i(wr_en), .wr_addr_i(wr_addr),
        .wr_data_i(wr_data), .rd_addr_i(rd_addr), .rd_data_o(rd_data),
        .tx_enable_o(tx_en), .rx_enable_o(rx_en), .irq_o(irq)
    );

    task automatic check(input logic ok, input string tag, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    task automatic step(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic wr(input logic a, input logic [3:0] d);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0; wr_data = '0;
    endtask

    task automatic rd(input logic a, output logic [3:0] d);
        rd_addr = a;
        #1;
        d = rd_data;
    endtask

    task automatic t_reset();
        logic [3:0] v;
        check(tx_en == 1 && rx_en == 1, "R1 enables", int'({tx_en, rx_en}), 3);
        check(irq == 0, "R1 irq", int'(irq), 0);
        rd(0, v); check(v == 0, "R1 control", int'(v), 0);
        rd(1, v); check(v == 0, "R1 status", int'(v), 0);
    endtask

    task automatic t_latency_glitch();
        logic [3:0] v;
        cts_n = 1'b0;
        step(DEB + 1);
        rd(1, v); check(v[0] == 0, "R6 early", int'(v[0]), 0);
        step(1);
        rd(1, v); check(v[0] == 1, "R6 exact/R2 level", int'(v[0]), 1);
        check(v[2] == 0, "R6 flag latency", int'(v[2]), 0);
        step(1);
        rd(1, v); check(v[2] == 1, "R7 cts fall flag", int'(v[2]), 1);
        check(tx_en && rx_en, "R2 open mode", int'({tx_en, rx_en}), 3);
        wr(1, 4'b1100);
        cts_n = 1'b1; step(DEB - 1); cts_n = 1'b0;
        step(12);
        rd(1, v); check(v == 4'b0001, "R6 glitch ignored", int'(v), 1);
        dcd_n = 1'b0; step(12);
        rd(1, v); check(v == 4'b1011, "R2 dcd level/R7", int'(v), 11);
        dcd_n = 1'b1; step(12);
        rd(1, v); check(v == 4'b1001, "R2 dcd release", int'(v), 9);
        wr(1, 4'b1100);
    endtask

    task automatic t_auto_tx();
        wr(0, 4'b0001);
        step(1);
        check(tx_en == 1, "R3 cts low opens", int'(tx_en), 1);
        check(rx_en == 0, "R5 dcd high closes", int'(rx_en), 0);
        cts_n = 1'b1;
        step(DEB + 2);
        check(tx_en == 1, "R6 tx latency early", int'(tx_en), 1);
        step(1);
        check(tx_en == 0, "R3 cts high closes", int'(tx_en), 0);
        cts_n = 1'b0; step(12);
        check(tx_en == 1, "R3 cts low reopens", int'(tx_en), 1);
    endtask

    task automatic t_hold_busy();
        busy = 1'b1;
        cts_n = 1'b1; step(15);
        check(tx_en == 1, "R4 holds while busy", int'(tx_en), 1);
        busy = 1'b0; step(1);
        check(tx_en == 0, "R4 drops after char", int'(tx_en), 0);
        cts_n = 1'b0; step(12);
        check(tx_en == 1, "R4 reopen", int'(tx_en), 1);
    endtask

    task automatic t_auto_rx();
        dcd_n = 1'b0; step(12);
        check(rx_en == 1, "R5 dcd low opens", int'(rx_en), 1);
        check(tx_en == 1, "R5 tx untouched", int'(tx_en), 1);
        dcd_n = 1'b1; step(12);
        check(rx_en == 0, "R5 dcd high closes", int'(rx_en), 0);
        wr(0, 4'b0000); step(1);
        check(rx_en == 1 && tx_en == 1, "R2 back to open", int'({tx_en, rx_en}), 3);
        wr(1, 4'b1100);
    endtask

    task automatic t_flags_irq();
        logic [3:0] v;
        wr(0, 4'b0010);
        dcd_n = 1'b0; step(12);
        rd(1, v); check(v[3] == 1, "R7 dcd fall flag", int'(v[3]), 1);
        check(irq == 0, "R9 dcd masked", int'(irq), 0);
        cts_n = 1'b1; step(12);
        rd(1, v); check(v[2] == 1, "R7 cts rise flag", int'(v[2]), 1);
        check(irq == 1, "R9 cts irq", int'(irq), 1);
        wr(1, 4'b0100);
        rd(1, v); check(v[3:2] == 2'b10, "R8 clear cts only", int'(v[3:2]), 2);
        check(irq == 0, "R9 irq drops", int'(irq), 0);
        wr(0, 4'b0100);
        check(irq == 1, "R9 dcd enabled", int'(irq), 1);
        wr(1, 4'b0000);
        rd(1, v); check(v[3] == 1, "R8 zero write keeps", int'(v[3]), 1);
        wr(1, 4'b1000);
        rd(1, v); check(v[3:2] == 2'b00, "R8 clear dcd", int'(v[3:2]), 0);
        check(irq == 0, "R9 irq clear", int'(irq), 0);
        dcd_n = 1'b1; step(12);
        rd(1, v); check(v[3] == 1, "R7 dcd rise flag", int'(v[3]), 1);
        check(irq == 1, "R9 dcd rise irq", int'(irq), 1);
    endtask

    initial begin
        #(CLK_PERIOD * 100000);
        n_bad++;
        $display("FAIL watchdog: actual 1 expected 0");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        step(3);
        rst_n = 1'b1;
        step(1);
        t_reset();
        t_latency_glitch();
        t_auto_tx();
        t_hold_busy();
        t_auto_rx();
        t_flags_irq();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule